// File: doc/BRIEF.md
# System Reset Control Register

This block is a one-byte I/O register that platform software uses to ask for a reset. It sits on a simple valid/ready I/O request channel whose data path is `DATA_W` bits wide. It claims only the single byte address given by `REG_ADDR`, which defaults to 0xCF9. On a wide bus the register lives in the byte lane picked by the low address bits, using little-endian lane order, so lane 1 on the default 32-bit bus. A request to any other address, or one without the register's byte enable, is not claimed: `req_ready` stays low.

A claimed write whose byte has the trigger bit (bit 2) set does not change the stored byte. Instead it produces a one-clock pulse on `rst_req` in the cycle after the write is accepted. A claimed write with bit 2 clear keeps only the reset-kind bit (bit 1) and forces every other bit to zero. Reads return the stored byte.

Every accepted access produces exactly one response beat on a registered valid/ready response channel. A read response carries the stored byte in the register's lane. A write response carries all-zero data. While a response waits for `rsp_ready`, it holds still and no new request is accepted, so back-pressure on the response side stalls the request side.

Top module: `sys_reset_ctl`

## Requirements
- R1: A request is claimed (`req_ready` high) only when `req_valid` is high, the address word matches `REG_ADDR` with the low lane bits ignored, and the byte enable of lane `REG_ADDR % (DATA_W/8)` is set; unclaimed requests leave the stored byte and `rst_req` untouched.
- R2: An accepted write whose register byte has bit 2 set drives `rst_req` high for exactly the one clock cycle after acceptance.
- R3: An accepted write whose register byte has bit 2 set leaves the stored byte unchanged.
- R4: An accepted write with bit 2 clear stores the written bit 1 in bit 1 and zero in bits 7:3, 2 and 0.
- R5: After reset the stored byte is 0x00, and `rst_req` and `rsp_valid` are low.
- R6: An accepted read gives `rsp_valid` high in the next cycle, with the stored byte in lane `REG_ADDR % (DATA_W/8)` of `rsp_rdata` and zero in the other lanes.
- R7: An accepted write gives one response beat in the next cycle, with `rsp_rdata` all zero.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold their values and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request claimed and accepted this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data, little-endian lanes |
| req_be | input | DATA_W/8 | Byte enables, one per lane |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W | Read data, zero for writes |
| rst_req | output | 1 | One-cycle platform reset request |

## Verification
The assertions assume that `rsp_ready` is a clean level sampled at the clock edge. They also assume the requester never depends on a request being held across cycles once `req_ready` was low, because an unclaimed access is simply dropped. The stimulus presents each request for one cycle and withdraws it after that edge whether it was claimed or not. It keeps `rsp_ready` high except in a deliberate stall window, where it holds it low for several cycles while offering a second request. The sweeps cover every value of the register byte and every byte-enable pattern at every byte address near the register.

// File: rtl/sys_reset_ctl_pkg.sv
package sys_reset_ctl_pkg;

  typedef enum logic [0:0] {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  function automatic logic [7:0] keep_kind_only(input logic [7:0] b, input int kind_pos);
    logic [7:0] r;
    r = 8'h00;
    r[kind_pos] = b[kind_pos];
    return r;
  endfunction

endpackage

// File: rtl/srst_decode.sv
module srst_decode #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0CF9
) (
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  hit,
  output logic [7:0]            wbyte
);
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_IDX = int'(REG_ADDR) % LANES;

  assign wbyte = req_wdata[LANE_IDX*8 +: 8];

  generate
    if (LANES == 1) begin : g_narrow
      assign hit = req_valid && (req_addr == REG_ADDR) && req_be[0];
    end else begin : g_wide
      localparam int LB = $clog2(LANES);
      assign hit = req_valid
                && (req_addr[ADDR_W-1:LB] == REG_ADDR[ADDR_W-1:LB])
                && req_be[LANE_IDX];
    end
  endgenerate
endmodule

// File: rtl/srst_store.sv
module srst_store #(
  parameter int TRIG_POS = 2,
  parameter int KIND_POS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic [7:0] wbyte,
  output logic [7:0] stored,
  output logic       rst_req
);
  import sys_reset_ctl_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored  <= 8'h00;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wr_fire && wbyte[TRIG_POS];
      if (wr_fire && !wbyte[TRIG_POS])
        stored <= keep_kind_only(wbyte, KIND_POS);
    end
  end

  assert_trig_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wbyte[TRIG_POS]) |=> rst_req);

  assert_trig_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wbyte[TRIG_POS]) |=> $stable(stored));

  assert_kind_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wbyte[TRIG_POS]) |=> (stored[KIND_POS] == $past(wbyte[KIND_POS]))
                                       && ($countones(stored) <= 1));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> !rst_req);
endmodule

// File: rtl/srst_resp.sv
module srst_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              can_take
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_rsp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
endmodule

// File: rtl/sys_reset_ctl.sv
module sys_reset_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0CF9,
  parameter int TRIG_POS = 2,
  parameter int KIND_POS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rst_req
);
  import sys_reset_ctl_pkg::*;

  localparam int LANES    = DATA_W / 8;
  localparam int LANE_IDX = int'(REG_ADDR) % LANES;

  logic              hit;
  logic [7:0]        wbyte;
  logic [7:0]        stored;
  logic              can_take;
  logic              accept;
  logic              wr_fire;
  logic [DATA_W-1:0] load_data;

  srst_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .hit       (hit),
    .wbyte     (wbyte)
  );

  assign req_ready = hit && can_take;
  assign accept    = req_ready;
  assign wr_fire   = accept && (acc_kind_e'(req_write) == ACC_WRITE);

  always_comb begin
    load_data = '0;
    if (acc_kind_e'(req_write) == ACC_READ)
      load_data[LANE_IDX*8 +: 8] = stored;
  end

  srst_store #(.TRIG_POS(TRIG_POS), .KIND_POS(KIND_POS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wbyte   (wbyte),
    .stored  (stored),
    .rst_req (rst_req)
  );

  srst_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .load_data (load_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .can_take  (can_take)
  );

  assert_claim_only_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ready);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_wr_rsp_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (rsp_rdata == '0));
endmodule

// File: tb/sys_reset_ctl_test.sv
`timescale 1ns/1ps
module sys_reset_ctl_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam logic [15:0] RA = 16'h0CF9;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic req_ready, rsp_valid, rst_req;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rsp_rdata;
  logic [3:0] req_be = '0;

  int checks = 0, failures = 0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  sys_reset_ctl uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle access; returns claim, response data, pulse
  task automatic access(input logic [15:0] a, input bit we, input logic [7:0] v,
                        input logic [3:0] be, output bit claimed,
                        output logic [31:0] rd, output bit pulse);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = we; req_be = be;
    req_wdata = {4{v}};
    #1 claimed = req_ready;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
    pulse = rst_req;
    if (claimed) chk(rsp_valid, "R6/R7 rsp_valid", rsp_valid, 1);
  endtask

  task automatic read_check(input string tag);
    bit c, p; logic [31:0] d;
    access(RA, 0, 8'h00, 4'b0010, c, d, p);
    chk(c, {tag, " read claim"}, c, 1);
    chk(d == {16'h0, model, 8'h00}, {tag, " R6 readback"}, d, {16'h0, model, 8'h00});
  endtask

  initial begin
    bit c, p; logic [31:0] d;
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid == 0 && rst_req == 0, "R5 outputs idle", {rsp_valid, rst_req}, 0);
    rst_n = 1;
    read_check("R5");

    // R2 R3 R4: sweep every byte value
    for (int v = 0; v < 256; v++) begin
      access(RA, 1, 8'(v), 4'b0010, c, d, p);
      chk(c, "R1 write claim", c, 1);
      chk(d == 0, "R7 write rsp zero", d, 0);
      chk(p == v[2], "R2 pulse", p, v[2]);
      @(negedge clk) #0;
      chk(rst_req == 0, "R2 single pulse", rst_req, 0);
      if (!v[2]) model = 8'(v) & 8'h02;
      read_check(v[2] ? "R3" : "R4");
    end

    // R1: addresses near the register, every byte-enable pattern
    for (int a = 16'h0CF0; a < 16'h0D00; a++) begin
      for (int be = 0; be < 16; be++) begin
        bit exp_c;
        exp_c = (a[15:2] == RA[15:2]) && be[1];
        access(16'(a), 1, exp_c ? 8'h00 : 8'h06, 4'(be), c, d, p);
        chk(c == exp_c, "R1 claim decode", c, exp_c);
        if (exp_c) model = 8'h00;
        else chk(p == 0, "R1 unclaimed no pulse", p, 0);
        if (be == 15 && !exp_c) read_check("R1 unclaimed untouched");
        else if (be == 15) model = 8'h00;
      end
      access(RA, 1, 8'h02, 4'b0010, c, d, p);
      model = 8'h02;
    end
    read_check("R1 final");

    // R8: response back-pressure
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_addr = RA; req_write = 0; req_be = 4'b0010;
    @(negedge clk);
    d = rsp_rdata;
    chk(rsp_valid, "R8 rsp raised", rsp_valid, 1);
    req_write = 1; req_wdata = 32'h0000_0400;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) #1;
      chk(rsp_valid && rsp_rdata == d, "R8 hold", rsp_rdata, d);
      chk(!req_ready, "R8 no accept", req_ready, 0);
      chk(!rst_req, "R8 no write while stalled", rst_req, 0);
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R8 drained", rsp_valid, 0);
    read_check("R8 after stall");

    // R5: reset clears stored byte
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    model = 8'h00;
    read_check("R5 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule